// File: doc/BRIEF.md
# Attenuation-Modulated Sample Player

This block turns packed digitized audio into a stream of command bytes for a three-voice square-wave sound generator that has no DAC. On a start pulse it first sets the tone divider of each voice it will use to a fixed, very small divider, which pushes those voices far above the audible band. It then rewrites the voices' 4-bit attenuation once per sample, so the loudness of the ultrasonic carrier follows the recorded waveform.

Samples are read one byte at a time from a memory port with a combinational read and are paced by an internal sample-period counter. Three packings are supported: two 4-bit samples per byte, eight 1-bit samples per byte, and a chasing mode. The chasing mode uses 4-bit samples but changes only one voice per sample slot. A shared option drives the same attenuation into all three voices for the loudest output. When the programmed number of bytes has been played, the block silences every voice it drove and raises a done flag.

Top module: `psg_sample_player`

## Requirements
- R1: After reset, psg_wr_o, busy_o and done_o are 0. No write is issued while the block is idle.
- R2: After a start pulse, and before any attenuation write, the block writes the tone divider TONE_DIV to each voice in use, in ascending voice order. Each voice gets two bytes: {1, voice[1:0], 0, div[3:0]} and then {00, div[9:4]}. The voices in use are all three voices when shared_i is 1 or the mode is chasing. Otherwise only voice chan_i (0 to 2) is used.
- R3: Every attenuation write has the form {1, voice[1:0], 1, att[3:0]} with att = 15 - level. The voice field never equals 3.
- R4: mode_i = 0 (and mode_i = 3) selects 4-bit mode. Each byte holds two samples, and the high nibble plays first. Bytes are read from addresses 0 up to len_i-1 in ascending order.
- R5: mode_i = 1 selects 1-bit mode. Each byte holds eight samples, and bit 7 plays first. A 1 bit gives level 15 (att 0). A 0 bit gives level 0 (att 15).
- R6: With shared_i = 1 in modes 0, 1 and 3, each sample writes voices 0, 1 and 2 on three consecutive cycles, all with the same attenuation.
- R7: The first attenuation write of consecutive samples occurs exactly rate_i cycles apart. rate_i must be at least 4.
- R8: mode_i = 2 selects chasing mode, which uses 4-bit samples. For each sample, at most one voice is written. The voice written is the one whose last written level is farthest from the sample level; a tie goes to the lower voice. Its attenuation is then set to match the sample. No write occurs when all three voices already match. All voices count as level 0 at start.
- R9: After the last sample of byte len_i-1, the block writes att 15 to each voice in use, in ascending order. done_o then rises on the same cycle as the final silencing write and stays high with busy_o low until the next start.
- R10: With len_i = 0, the tone setup is followed directly by the silencing writes and done. No sample is played.
- R11: A start pulse while busy_o is high is ignored. The write sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; configuration is captured on this cycle |
| mode_i | input | 2 | 0/3: 4-bit, 1: 1-bit, 2: chasing |
| shared_i | input | 1 | Drive all three voices with the same attenuation |
| chan_i | input | 2 | Voice used when neither shared nor chasing (0 to 2) |
| rate_i | input | DIV_W | Sample period in clock cycles (at least 4) |
| len_i | input | LEN_W | Number of bytes to play |
| mem_addr_o | output | LEN_W | Byte address of the current sample byte |
| mem_data_i | input | 8 | Byte at mem_addr_o, valid in the same cycle |
| psg_wr_o | output | 1 | Command byte write strobe |
| psg_data_o | output | 8 | Command byte to the sound generator |
| busy_o | output | 1 | Playback sequence in progress |
| done_o | output | 1 | Sequence finished; held until the next start |

## Verification
The bench builds the block with DIV_W = 8 and LEN_W = 6. It sets TONE_DIV to 0x2A5, so both divider bytes carry nonzero bits and a swapped or truncated divider field is visible. The short byte counts keep each run brief, which lets a run cover every packing, the shared and single-voice paths, ties in the chasing choice, the minimum sample period of 4 and a zero length. The random runs mix modes and periods with random sample bytes, and the directed runs pin the nibble order, the bit order and the chasing tie rule.

// File: rtl/psg_play_pkg.sv
package psg_play_pkg;

  typedef enum logic [1:0] {
    MODE_NIB   = 2'd0,
    MODE_BIT   = 2'd1,
    MODE_CHASE = 2'd2,
    MODE_NIB2  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_TONE,
    S_PLAY,
    S_SILENCE
  } state_e;

  localparam int unsigned NUM_VOICES = 3;

  function automatic logic [7:0] att_cmd(input logic [1:0] ch, input logic [3:0] att);
    return {1'b1, ch, 1'b1, att};
  endfunction

  function automatic logic [7:0] tone_lo(input logic [1:0] ch, input logic [9:0] div);
    return {1'b1, ch, 1'b0, div[3:0]};
  endfunction

  function automatic logic [7:0] tone_hi(input logic [9:0] div);
    return {2'b00, div[9:4]};
  endfunction

endpackage

// File: rtl/psg_rate_tick.sv
module psg_rate_tick #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] period_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == period_i - 1'b1);
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/psg_unpack.sv
module psg_unpack (
  input  logic [7:0] byte_i,
  input  logic [2:0] sub_i,
  input  logic       one_bit_i,
  output logic [3:0] level_o
);
  logic bit_v;

  assign bit_v = byte_i[3'd7 - sub_i];

  always_comb begin
    if (one_bit_i)     level_o = bit_v ? 4'hF : 4'h0;
    else if (sub_i[0]) level_o = byte_i[3:0];
    else               level_o = byte_i[7:4];
  end
endmodule

// File: rtl/psg_chase_pick.sv
module psg_chase_pick
  import psg_play_pkg::*;
(
  input  logic [3:0]                 target_i,
  input  logic [NUM_VOICES-1:0][3:0] lvl_i,
  output logic [1:0]                 ch_o,
  output logic                       nz_o
);
  logic [NUM_VOICES-1:0][3:0] err;

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_err
    assign err[v] = (target_i >= lvl_i[v]) ? target_i - lvl_i[v] : lvl_i[v] - target_i;
  end

  // strict compare keeps ties on the lower voice
  always_comb begin
    ch_o = 2'd0;
    if (err[1] > err[0])    ch_o = 2'd1;
    if (err[2] > err[ch_o]) ch_o = 2'd2;
    nz_o = (err[ch_o] != 4'd0);
  end
endmodule

// File: rtl/psg_sample_player.sv
module psg_sample_player
  import psg_play_pkg::*;
#(
  parameter int unsigned DIV_W    = 12,
  parameter int unsigned LEN_W    = 16,
  parameter logic [9:0]  TONE_DIV = 10'd1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             shared_i,
  input  logic [1:0]       chan_i,
  input  logic [DIV_W-1:0] rate_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] mem_addr_o,
  input  logic [7:0]       mem_data_i,
  output logic             psg_wr_o,
  output logic [7:0]       psg_data_o,
  output logic             busy_o,
  output logic             done_o
);
  state_e                     state_q;
  mode_e                      mode_q;
  logic                       shared_q;
  logic [1:0]                 chan_q;
  logic [DIV_W-1:0]           rate_q;
  logic [LEN_W-1:0]           len_q, addr_q;
  logic [2:0]                 sub_q, step_q;
  logic [1:0]                 pend_q;
  logic [3:0]                 att_q;
  logic [NUM_VOICES-1:0][3:0] cur_q;
  logic                       last_q, done_q, wr_q;
  logic [7:0]                 data_q;

  logic       multi, one_bit, sub_last, last_smp, tick, pick_nz;
  logic [3:0] level;
  logic [1:0] pick_ch, tone_ch;

  assign multi    = shared_q || (mode_q == MODE_CHASE);
  assign one_bit  = (mode_q == MODE_BIT);
  assign sub_last = one_bit ? (sub_q == 3'd7) : sub_q[0];
  assign last_smp = sub_last && (addr_q == len_q - 1'b1);
  assign tone_ch  = multi ? step_q[2:1] : chan_q;

  psg_rate_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q == S_PLAY),
    .period_i(rate_q),
    .tick_o  (tick)
  );

  psg_unpack u_unpack (
    .byte_i   (mem_data_i),
    .sub_i    (sub_q),
    .one_bit_i(one_bit),
    .level_o  (level)
  );

  psg_chase_pick u_pick (
    .target_i(level),
    .lvl_i   (cur_q),
    .ch_o    (pick_ch),
    .nz_o    (pick_nz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      mode_q   <= MODE_NIB;
      shared_q <= 1'b0;
      chan_q   <= '0;
      rate_q   <= '0;
      len_q    <= '0;
      addr_q   <= '0;
      sub_q    <= '0;
      step_q   <= '0;
      pend_q   <= '0;
      att_q    <= '0;
      cur_q    <= '0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
      wr_q     <= 1'b0;
      data_q   <= '0;
    end else begin
      wr_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          mode_q   <= mode_e'(mode_i);
          shared_q <= shared_i;
          chan_q   <= chan_i;
          rate_q   <= rate_i;
          len_q    <= len_i;
          addr_q   <= '0;
          sub_q    <= '0;
          step_q   <= '0;
          pend_q   <= '0;
          cur_q    <= '0;
          last_q   <= 1'b0;
          done_q   <= 1'b0;
          state_q  <= S_TONE;
        end
        S_TONE: begin
          wr_q   <= 1'b1;
          data_q <= step_q[0] ? tone_hi(TONE_DIV) : tone_lo(tone_ch, TONE_DIV);
          if (step_q == (multi ? 3'd5 : 3'd1)) begin
            step_q  <= '0;
            state_q <= (len_q == '0) ? S_SILENCE : S_PLAY;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        S_PLAY: begin
          if (last_q && pend_q == 2'd0) begin
            step_q  <= '0;
            state_q <= S_SILENCE;
          end else if (pend_q != 2'd0) begin
            wr_q   <= 1'b1;
            data_q <= att_cmd(step_q[1:0], att_q);
            step_q <= step_q + 1'b1;
            pend_q <= pend_q - 1'b1;
          end else if (tick) begin
            last_q <= last_smp;
            if (!sub_last)     sub_q <= sub_q + 1'b1;
            else if (!last_smp) begin
              sub_q  <= '0;
              addr_q <= addr_q + 1'b1;
            end
            if (mode_q == MODE_CHASE) begin
              if (pick_nz) begin
                wr_q           <= 1'b1;
                data_q         <= att_cmd(pick_ch, ~level);
                cur_q[pick_ch] <= level;
              end
            end else if (shared_q) begin
              wr_q   <= 1'b1;
              data_q <= att_cmd(2'd0, ~level);
              att_q  <= ~level;
              pend_q <= 2'd2;
              step_q <= 3'd1;
            end else begin
              wr_q   <= 1'b1;
              data_q <= att_cmd(chan_q, ~level);
            end
          end
        end
        S_SILENCE: begin
          wr_q   <= 1'b1;
          data_q <= att_cmd(multi ? step_q[1:0] : chan_q, 4'hF);
          if (step_q == (multi ? 3'd2 : 3'd0)) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_addr_o = addr_q;
  assign psg_wr_o   = wr_q;
  assign psg_data_o = data_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/psg_sample_player_chk.sv
module psg_sample_player_chk #(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             psg_wr_o,
  input logic [7:0]       psg_data_o,
  input logic [LEN_W-1:0] mem_addr_o,
  input logic [LEN_W-1:0] len_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> !psg_wr_o); // R1

  AST_VOICE_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psg_wr_o && psg_data_o[7]) |-> (psg_data_o[6:5] != 2'b11)); // R3

  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && len_q != '0) |-> (mem_addr_o < len_q)); // R4

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9

  AST_DONE_SILENCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (psg_wr_o && psg_data_o[4] && psg_data_o[3:0] == 4'hF)); // R9

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(len_q)); // R11
endmodule

bind psg_sample_player psg_sample_player_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .psg_wr_o  (psg_wr_o),
  .psg_data_o(psg_data_o),
  .mem_addr_o(mem_addr_o),
  .len_q     (len_q)
);

// File: tb/psg_sample_player_test.sv
module psg_sample_player_test;
  localparam int unsigned DIV_W = 8;
  localparam int unsigned LEN_W = 6;
  localparam logic [9:0]  TDIV  = 10'h2A5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [1:0]       mode_i = '0;
  logic             shared_i = 1'b0;
  logic [1:0]       chan_i = '0;
  logic [DIV_W-1:0] rate_i = 8'd4;
  logic [LEN_W-1:0] len_i = '0;
  logic [LEN_W-1:0] mem_addr_o;
  logic [7:0]       mem_data_i;
  logic             psg_wr_o, busy_o, done_o;
  logic [7:0]       psg_data_o;

  logic [7:0] mem [0:63];
  assign mem_data_i = mem[mem_addr_o];

  always #10 clk_i = ~clk_i;

  psg_sample_player #(.DIV_W(DIV_W), .LEN_W(LEN_W), .TONE_DIV(TDIV)) uut (.*);

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] got[$], exp_q[$];
  int stamp[$], efirst[$], esmp[$];
  int ntone, nsil;

  always @(negedge clk_i) begin
    cyc++;
    if (psg_wr_o) begin
      got.push_back(psg_data_o);
      stamp.push_back(cyc);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] att_b(input int ch, input int att);
    return {1'b1, 2'(ch), 1'b1, 4'(att)};
  endfunction

  task automatic build(input int mode, input bit shr, input int ch, input int len);
    bit multi = shr || mode == 2;
    int nv = multi ? 3 : 1;
    int nsmp = (mode == 1) ? 8 : 2;
    int cur[3] = '{0, 0, 0};
    int smp = 0;
    exp_q.delete(); efirst.delete(); esmp.delete();
    for (int v = 0; v < nv; v++) begin
      int c = multi ? v : ch;
      exp_q.push_back({1'b1, 2'(c), 1'b0, TDIV[3:0]});
      exp_q.push_back({2'b00, TDIV[9:4]});
    end
    ntone = 2 * nv;
    for (int b = 0; b < len; b++) begin
      for (int s = 0; s < nsmp; s++) begin
        int lvl;
        if (mode == 1) lvl = mem[b][7-s] ? 15 : 0;
        else           lvl = (s == 0) ? int'(mem[b][7:4]) : int'(mem[b][3:0]);
        if (mode == 2) begin
          int best = 0;
          int e[3];
          for (int v = 0; v < 3; v++) e[v] = (lvl >= cur[v]) ? lvl - cur[v] : cur[v] - lvl;
          if (e[1] > e[0]) best = 1;
          if (e[2] > e[best]) best = 2;
          if (e[best] != 0) begin
            efirst.push_back(exp_q.size()); esmp.push_back(smp);
            exp_q.push_back(att_b(best, 15 - lvl));
            cur[best] = lvl;
          end
        end else begin
          efirst.push_back(exp_q.size()); esmp.push_back(smp);
          if (shr) for (int v = 0; v < 3; v++) exp_q.push_back(att_b(v, 15 - lvl));
          else exp_q.push_back(att_b(ch, 15 - lvl));
        end
        smp++;
      end
    end
    for (int v = 0; v < nv; v++) exp_q.push_back(att_b(multi ? v : ch, 15));
    nsil = nv;
  endtask

  task automatic run(input int mode, input bit shr, input int ch, input int len,
                     input int rate, input string req, input bit intf);
    int t = 0;
    build(mode, shr, ch, len);
    got.delete(); stamp.delete();
    @(negedge clk_i);
    mode_i = 2'(mode); shared_i = shr; chan_i = 2'(ch); rate_i = 8'(rate); len_i = 6'(len);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (intf) begin
      repeat (12) @(negedge clk_i);
      mode_i = 2'(mode ^ 1); shared_i = !shr; len_i = 6'(len + 3); rate_i = 8'(rate + 2);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o && t < 5000) begin
      @(negedge clk_i); t++;
    end
    chk(t < 5000, "R9", "timeout waiting for done", t, 5000);
    repeat (2) @(negedge clk_i);
    chk(done_o && !busy_o, "R9", "done high and busy low", {done_o, busy_o}, 2'b10);
    chk(got.size() == exp_q.size(), req, "write count", got.size(), exp_q.size());
    if (got.size() == exp_q.size()) begin
      int bad = -1;
      for (int i = 0; i < ntone; i++) if (bad < 0 && got[i] != exp_q[i]) bad = i;
      chk(bad < 0, "R2", "tone setup byte", bad < 0 ? 0 : got[bad], bad < 0 ? 0 : exp_q[bad]);
      bad = -1;
      for (int i = ntone; i < exp_q.size() - nsil; i++) if (bad < 0 && got[i] != exp_q[i]) bad = i;
      chk(bad < 0, req, "sample byte", bad < 0 ? 0 : got[bad], bad < 0 ? 0 : exp_q[bad]);
      bad = -1;
      for (int i = exp_q.size() - nsil; i < exp_q.size(); i++) if (bad < 0 && got[i] != exp_q[i]) bad = i;
      chk(bad < 0, "R9", "silencing byte", bad < 0 ? 0 : got[bad], bad < 0 ? 0 : exp_q[bad]);
      bad = -1;
      for (int k = 1; k < efirst.size(); k++)
        if (bad < 0 && stamp[efirst[k]] - stamp[efirst[k-1]] != rate * (esmp[k] - esmp[k-1])) bad = k;
      if (efirst.size() > 1)
        chk(bad < 0, "R7", "sample spacing",
            bad < 0 ? 0 : stamp[efirst[bad]] - stamp[efirst[bad-1]],
            bad < 0 ? 0 : rate * (esmp[bad] - esmp[bad-1]));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(!psg_wr_o && !busy_o && !done_o, "R1", "outputs in reset", {psg_wr_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(!psg_wr_o && !busy_o && !done_o, "R1", "outputs after reset", {psg_wr_o, busy_o, done_o}, 0);

    // R4: nibble order, single voice
    mem[0] = 8'h3C; mem[1] = 8'hF0; mem[2] = 8'h81;
    run(0, 1'b0, 2, 3, 5, "R4", 1'b0);
    // R5: bit order, shared
    mem[0] = 8'hA5; mem[1] = 8'h0F;
    run(1, 1'b1, 0, 2, 6, "R5", 1'b0);
    // R6 with R7 at the minimum period
    mem[0] = 8'h7E; mem[1] = 8'h19;
    run(3, 1'b1, 1, 2, 4, "R6", 1'b0);
    // R8: chasing with ties and a repeated level
    mem[0] = 8'h88; mem[1] = 8'h88; mem[2] = 8'hF0; mem[3] = 8'h00;
    run(2, 1'b0, 0, 4, 7, "R8", 1'b0);
    // R10: zero length
    run(0, 1'b0, 1, 0, 5, "R10", 1'b0);
    run(2, 1'b1, 0, 0, 5, "R10", 1'b0);
    // R11: start while busy
    mem[0] = 8'h5A; mem[1] = 8'hC3; mem[2] = 8'h96;
    run(0, 1'b0, 0, 3, 9, "R11", 1'b1);
    run(1, 1'b1, 2, 2, 5, "R11", 1'b1);

    // R3: random mix, attenuation format checked through the byte stream
    for (int r = 0; r < 10; r++) begin
      int m = int'($urandom % 4);
      for (int i = 0; i < 8; i++) mem[i] = 8'($urandom);
      run(m, 1'($urandom), int'($urandom % 3), 1 + int'($urandom % 5),
          4 + int'($urandom % 8), "R3", 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule